// File: doc/BRIEF.md
# Receive FIFO with Threshold Flow Control

This block buffers 8-bit characters coming from a UART receiver and presents them to software through a receive holding register. Software can read that register one byte at a time or one word at a time. A word read in multiple-data mode removes up to four characters in a single access. In single-data mode, which the character-format and protocol selectors force, a word read removes only one character.

The block also drives the request-to-send line from its fill level. Two programmable thresholds set the behaviour. At or above the high threshold the line goes high, which tells the peer to stop sending. At or below the low threshold it goes low, which asks the peer for more data. Between the two thresholds the line keeps its previous value, so the block has hysteresis. A character that arrives while the buffer is full is dropped, and a sticky overrun flag records the loss.

Read results are registered. The cycle after a read request, `rd_data_o` and `rd_cnt_o` show the characters that were removed. Both outputs hold their values until the next read.

Top module: `rx_fifo_flow`

## Requirements
- R1: After reset `fill_o` is 0, `empty_o` is 1, `full_o` is 0, `rts_o` is 0, `ovr_o` is 0, `rd_cnt_o` is 0 and `rd_data_o` is 0.
- R2: A write with `wr_valid_i` while fewer than DEPTH characters are stored keeps the character and raises `fill_o` by one. `full_o` is 1 exactly when `fill_o` equals DEPTH, and `empty_o` is 1 exactly when `fill_o` is 0.
- R3: A write while `fill_o` equals DEPTH is dropped and `fill_o` does not change. Such a write sets `ovr_o`, which stays set until `ovr_clr_i`. When a drop and a clear happen in the same cycle, the set wins.
- R4: A byte read (`rd_req_i` with `rd_word_i`=0) removes the oldest character. In the next cycle that character is in `rd_data_o[7:0]`, bits 31:8 are zero and `rd_cnt_o` is 1.
- R5: In multiple-data mode a word read (`rd_word_i`=1) removes min(4, `fill_o`) characters. The oldest character goes in bits 7:0, the next in 15:8, then 23:16, then 31:24. Unused byte lanes are zero, and `rd_cnt_o` gives the number of characters removed.
- R6: The block is in single-data mode when `nine_bit_i` is 1 or `op_mode_i` is 4, 5 or 6. All other values give multiple-data mode. In single-data mode a word read behaves exactly like a byte read.
- R7: A read while `fill_o` is 0 gives `rd_cnt_o`=0 and `rd_data_o`=0, and it leaves `fill_o` unchanged.
- R8: While `rts_ctl_en_i` is 1, `rts_o` is 1 whenever `fill_o` is at or above `thr_hi_i`. If the two thresholds are equal, the high rule wins.
- R9: While `rts_ctl_en_i` is 1, `rts_o` is 0 whenever `fill_o` is at or below `thr_lo_i` and below `thr_hi_i`.
- R10: While `rts_ctl_en_i` is 1 and `fill_o` is strictly between the thresholds, `rts_o` keeps its previous value.
- R11: While `rts_ctl_en_i` is 0, `rts_o` is 0 one cycle after the enable drops.
- R12: A read and a write in the same cycle are both performed. Whether the write is accepted depends on the fill level before the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Character strobe from the receiver |
| wr_data_i | input | 8 | Received character |
| rd_req_i | input | 1 | Holding-register read request |
| rd_word_i | input | 1 | Access size: 1 = word (32-bit), 0 = byte |
| rd_data_o | output | 32 | Characters from the last read, oldest in the low byte |
| rd_cnt_o | output | 3 | Number of characters removed by the last read |
| thr_lo_i | input | CNT_W | Low fill threshold |
| thr_hi_i | input | CNT_W | High fill threshold |
| rts_ctl_en_i | input | 1 | Enables threshold control of RTS |
| nine_bit_i | input | 1 | 9-bit character format selected |
| op_mode_i | input | 3 | Operating mode field (4, 5, 6 = single-data protocol modes) |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rts_o | output | 1 | Request-to-send line, 1 = stop sending |
| fill_o | output | CNT_W | Characters stored |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The bench targets these corner cases and the faults they would expose:
- **Partial word reads.** It reads a word with fewer than four characters stored. A design that popped a fixed four would underflow, and one that left stale lanes would return garbage in the upper bytes.
- **Mode selection.** It drives word reads under each single-data selector, which catches a wrong mode decode that drains several characters.
- **Write against a full buffer.** It writes into a full buffer, both alone and together with a read. An acceptance rule based on the post-read level would store a character that should be dropped, and a non-sticky overrun flag would lose the record of the drop.
- **Flow-control boundaries.** It walks the fill level up and down through both thresholds and runs the equal-threshold case. A design without hysteresis would drop RTS as soon as the level fell below the high threshold.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int NUM_W  = $clog2(LANES + 1);

  localparam logic [2:0] MODE_BUS_MASTER = 3'd4;
  localparam logic [2:0] MODE_BUS_SLAVE  = 3'd5;
  localparam logic [2:0] MODE_NODE_NET   = 3'd6;

  typedef enum logic {FIFO_MULTI = 1'b0, FIFO_SINGLE = 1'b1} fifo_mode_e;
endpackage

// File: rtl/rxf_mode_dec.sv
module rxf_mode_dec
  import rxf_pkg::*;
(
  input  logic       nine_bit_i,
  input  logic [2:0] op_mode_i,
  output fifo_mode_e mode_o
);
  logic proto_single;

  always_comb begin
    unique case (op_mode_i)
      MODE_BUS_MASTER, MODE_BUS_SLAVE, MODE_NODE_NET: proto_single = 1'b1;
      default:                                        proto_single = 1'b0;
    endcase
    mode_o = (nine_bit_i || proto_single) ? FIFO_SINGLE : FIFO_MULTI;
  end
endmodule

// File: rtl/rxf_buf.sv
module rxf_buf
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic [LANE_W-1:0]       wdata_i,
  input  logic [NUM_W-1:0]        pop_n_i,
  output logic [LANE_W-1:0]       peek_o [LANES],
  output logic [CNT_W-1:0]        cnt_o,
  output logic [CNT_W-1:0]        cnt_nxt_o
);
  logic [LANE_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  // pointers wrap naturally: DEPTH is a power of two
  always_comb begin
    cnt_nxt_o = cnt_q + CNT_W'(push_i) - CNT_W'(pop_n_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n_i);
      cnt_q    <= cnt_nxt_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    assign peek_o[k] = mem_q[rd_ptr_q + PTR_W'(k)];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rxf_rts_ctrl.sv
module rxf_rts_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             rts_o
);
  logic rts_q, rts_d;

  always_comb begin
    rts_d = rts_q;
    if (!en_i)                rts_d = 1'b0;
    else if (level_i >= hi_i) rts_d = 1'b1;   // stop wins on equal thresholds
    else if (level_i <= lo_i) rts_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rts_q <= 1'b0;
    else         rts_q <= rts_d;
  end

  assign rts_o = rts_q;
endmodule

// File: rtl/rx_fifo_flow.sv
module rx_fifo_flow
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_req_i,
  input  logic              rd_word_i,
  output logic [31:0]       rd_data_o,
  output logic [2:0]        rd_cnt_o,
  input  logic [CNT_W-1:0]  thr_lo_i,
  input  logic [CNT_W-1:0]  thr_hi_i,
  input  logic              rts_ctl_en_i,
  input  logic              nine_bit_i,
  input  logic [2:0]        op_mode_i,
  input  logic              ovr_clr_i,
  output logic              rts_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovr_o
);
  fifo_mode_e        mode;
  logic [LANE_W-1:0] peek [LANES];
  logic [CNT_W-1:0]  cnt, cnt_nxt;
  logic              push, is_full;
  logic [NUM_W-1:0]  want, pop_n;
  logic [WORD_W-1:0] rdata_d, rdata_q;
  logic [NUM_W-1:0]  rcnt_q;
  logic              ovr_q;

  rxf_mode_dec u_mode (
    .nine_bit_i (nine_bit_i),
    .op_mode_i  (op_mode_i),
    .mode_o     (mode)
  );

  // acceptance judged on the level before any same-cycle read
  assign is_full = (cnt == CNT_W'(DEPTH));
  assign push    = wr_valid_i && !is_full;

  always_comb begin
    want  = (rd_word_i && mode == FIFO_MULTI) ? NUM_W'(LANES) : NUM_W'(1);
    pop_n = '0;
    if (rd_req_i) pop_n = (cnt < CNT_W'(want)) ? NUM_W'(cnt) : want;
  end

  rxf_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .wdata_i   (wr_data_i),
    .pop_n_i   (pop_n),
    .peek_o    (peek),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign rdata_d[k*LANE_W +: LANE_W] = (NUM_W'(k) < pop_n) ? peek[k] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rcnt_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (rd_req_i) begin
        rdata_q <= rdata_d;
        rcnt_q  <= pop_n;
      end
      if (wr_valid_i && is_full) ovr_q <= 1'b1;
      else if (ovr_clr_i)        ovr_q <= 1'b0;
    end
  end

  rxf_rts_ctrl #(.CNT_W(CNT_W)) u_rts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rts_ctl_en_i),
    .lo_i    (thr_lo_i),
    .hi_i    (thr_hi_i),
    .level_i (cnt_nxt),
    .rts_o   (rts_o)
  );

  assign rd_data_o = rdata_q;
  assign rd_cnt_o  = 3'(rcnt_q);
  assign fill_o    = cnt;
  assign empty_o   = (cnt == '0);
  assign full_o    = is_full;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/rx_fifo_flow_chk.sv
module rx_fifo_flow_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             rd_req_i,
  input logic [2:0]       rd_cnt_o,
  input logic [CNT_W-1:0] thr_lo_i,
  input logic [CNT_W-1:0] thr_hi_i,
  input logic             rts_ctl_en_i,
  input logic             ovr_clr_i,
  input logic             rts_o,
  input logic [CNT_W-1:0] fill_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             ovr_o
);
  AST_FULL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (fill_o == CNT_W'(DEPTH)));  // R2
  AST_EMPTY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (fill_o == '0));  // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_valid_i && !rd_req_i |=> full_o && ovr_o);  // R3
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o && !ovr_clr_i |=> ovr_o);  // R3
  AST_RD_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_o <= 3'd4);  // R5
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_req_i && !wr_valid_i |=> rd_cnt_o == 3'd0 && empty_o);  // R7
  AST_RTS_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_ctl_en_i && $stable(rts_ctl_en_i) && $stable(thr_hi_i) && fill_o >= thr_hi_i |-> rts_o);  // R8
  AST_RTS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_ctl_en_i && $stable(rts_ctl_en_i) && $stable(thr_lo_i) && $stable(thr_hi_i)
    && fill_o <= thr_lo_i && fill_o < thr_hi_i |-> !rts_o);  // R9
  AST_RTS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_ctl_en_i && !wr_valid_i && !rd_req_i && $stable(rts_ctl_en_i)
    && $stable(thr_lo_i) && $stable(thr_hi_i) |=> $stable(rts_o));  // R10
  AST_RTS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_ctl_en_i |=> !rts_o);  // R11
endmodule

bind rx_fifo_flow rx_fifo_flow_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .rd_req_i     (rd_req_i),
  .rd_cnt_o     (rd_cnt_o),
  .thr_lo_i     (thr_lo_i),
  .thr_hi_i     (thr_hi_i),
  .rts_ctl_en_i (rts_ctl_en_i),
  .ovr_clr_i    (ovr_clr_i),
  .rts_o        (rts_o),
  .fill_o       (fill_o),
  .empty_o      (empty_o),
  .full_o       (full_o),
  .ovr_o        (ovr_o)
);

// File: tb/rx_fifo_flow_tb_top.sv
module rx_fifo_flow_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [1:0]  op;      // 0 write, 1 byte read, 2 word read
    logic [7:0]  wdata;
    logic [31:0] exp_data;
    logic [2:0]  exp_cnt;
    logic [4:0]  exp_fill;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h11, 32'h0, 3'd0, 5'd1},
    '{2'd0, 8'h22, 32'h0, 3'd0, 5'd2},
    '{2'd0, 8'h33, 32'h0, 3'd0, 5'd3},
    '{2'd0, 8'h44, 32'h0, 3'd0, 5'd4},
    '{2'd0, 8'h55, 32'h0, 3'd0, 5'd5},
    '{2'd0, 8'h66, 32'h0, 3'd0, 5'd6},
    '{2'd2, 8'h00, 32'h44332211, 3'd4, 5'd2},
    '{2'd1, 8'h00, 32'h00000055, 3'd1, 5'd1},
    '{2'd2, 8'h00, 32'h00000066, 3'd1, 5'd0},
    '{2'd2, 8'h00, 32'h00000000, 3'd0, 5'd0},
    '{2'd0, 8'h77, 32'h0, 3'd0, 5'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, rd_req = 0, rd_word = 0, rts_en = 0, nine_bit = 0, ovr_clr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] op_mode = 0;
  logic [CNT_W-1:0] thr_lo = 0, thr_hi = 0;
  logic [31:0] rd_data;
  logic [2:0] rd_cnt;
  logic rts, empty, full, ovr;
  logic [CNT_W-1:0] fill;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_fifo_flow #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_req_i(rd_req), .rd_word_i(rd_word), .rd_data_o(rd_data), .rd_cnt_o(rd_cnt),
    .thr_lo_i(thr_lo), .thr_hi_i(thr_hi), .rts_ctl_en_i(rts_en), .nine_bit_i(nine_bit),
    .op_mode_i(op_mode), .ovr_clr_i(ovr_clr), .rts_o(rts), .fill_o(fill),
    .empty_o(empty), .full_o(full), .ovr_o(ovr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge, return at next negedge
  task automatic step(input logic w, input logic [7:0] d, input logic r, input logic word);
    wr_valid = w; wr_data = d; rd_req = r; rd_word = word;
    @(negedge clk);
    wr_valid = 0; rd_req = 0; ovr_clr = 0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 fill", 32'(fill), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 rts", 32'(rts), 0);
    chk("R1 ovr", 32'(ovr), 0);
    chk("R1 rd_cnt", 32'(rd_cnt), 0);
    rst_n = 1;
    @(negedge clk);

    // table walk, multi-data mode: R2 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].op == 2'd0, VEC[i].wdata, VEC[i].op != 2'd0, VEC[i].op == 2'd2);
      chk("R2 fill", 32'(fill), 32'(VEC[i].exp_fill));
      if (VEC[i].op != 2'd0) begin
        chk("R5 rd_data", rd_data, VEC[i].exp_data);
        chk("R4 rd_cnt", 32'(rd_cnt), 32'(VEC[i].exp_cnt));
      end
    end
    step(0, 0, 1, 1);  // drain 0x77
    chk("R5 drain", rd_data, 32'h77);

    // R6 single-data selectors
    for (int m = 0; m < 4; m++) begin
      nine_bit = (m == 0);
      op_mode  = (m == 0) ? 3'd3 : 3'(3 + m);
      step(1, 8'hA0, 0, 0); step(1, 8'hA1, 0, 0);
      step(0, 0, 1, 1);
      chk(m == 3 ? "R6 mode6" : "R6 single", 32'(rd_cnt), 1);
      chk("R6 data", rd_data, 32'hA0);
      step(0, 0, 1, 0);
    end
    nine_bit = 0; op_mode = 3'd3;
    step(1, 8'hB0, 0, 0); step(1, 8'hB1, 0, 0);
    step(0, 0, 1, 1);
    chk("R6 multi mode3", rd_data, 32'h0000B1B0);

    // R3 full and overrun
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 0, 0);
    chk("R2 full", 32'(full), 1);
    step(1, 8'hEE, 0, 0);
    chk("R3 fill held", 32'(fill), DEPTH);
    chk("R3 ovr set", 32'(ovr), 1);
    step(0, 0, 0, 0);
    chk("R3 sticky", 32'(ovr), 1);
    ovr_clr = 1; step(1, 8'hEF, 0, 0);
    chk("R3 set wins", 32'(ovr), 1);
    ovr_clr = 1; step(0, 0, 0, 0);
    chk("R3 cleared", 32'(ovr), 0);
    // R12 read+write at full: write dropped
    step(1, 8'hDD, 1, 0);
    chk("R12 fill", 32'(fill), DEPTH - 1);
    chk("R12 ovr", 32'(ovr), 1);
    chk("R12 data", rd_data, 32'h0);
    step(1, 8'hDE, 1, 0);
    chk("R12 both", 32'(fill), DEPTH - 1);
    ovr_clr = 1; step(0, 0, 0, 0);
    for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 1, 0);
    chk("R12 last", rd_data, 32'hDE);

    // RTS hysteresis
    thr_lo = 5'd3; thr_hi = 5'd8; rts_en = 1;
    step(0, 0, 0, 0);
    chk("R9 empty", 32'(rts), 0);
    for (int i = 0; i < 7; i++) step(1, 8'h5A, 0, 0);
    chk("R9 below hi", 32'(rts), 0);
    step(1, 8'h5A, 0, 0);
    chk("R8 at hi", 32'(rts), 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0);
    chk("R10 hold high", 32'(rts), 1);
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    chk("R9 at lo", 32'(rts), 0);
    step(1, 8'h5A, 0, 0); step(1, 8'h5A, 0, 0);
    chk("R10 hold low", 32'(rts), 0);
    thr_lo = 5'd5; thr_hi = 5'd5; step(0, 0, 0, 0);
    chk("R8 equal thr", 32'(rts), 1);
    rts_en = 0; step(0, 0, 0, 0);
    chk("R11 disabled", 32'(rts), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule